// File: doc/BRIEF.md
# Cascadable synchronous counter

This block is a binary up-counter of parameterised width (4 bits by default). It has an asynchronous active-low clear, a synchronous active-low parallel load and two count enables. One enable only gates counting. The other gates both counting and the terminal-count carry. The carry is a combinational function of the stored count and that second enable. This lets several instances be chained into a wider counter in which every stage advances on the same clock edge.

To build a wide counter, tie the carry of each stage to both enables of the next stage. Share the clock, clear and load strobe across all stages. Split the preset word across the stages' data inputs.

On each rising edge a small operation decoder picks one of three named operations: LOAD, COUNT or HOLD. It moves to LOAD whenever the load strobe is low. It moves to COUNT when the load strobe is high and both enables are high. It moves to HOLD in every other case. Clear is not a decoded operation. It acts on the register directly and overrides everything else.

Top module: `casc_counter`

## Requirements
- R1: While `clear_n` is low, `q` is all zeros at once, without waiting for a clock edge and whatever the other inputs are.
- R2: With `clear_n` high, a rising edge with `load_n` low copies `din` into `q`, whatever `en_count` and `en_ripple` are.
- R3: With `clear_n` and `load_n` high and both `en_count` and `en_ripple` high, each rising edge adds one to `q`.
- R4: With `clear_n` and `load_n` high and either enable low, a rising edge leaves `q` unchanged.
- R5: Counting from the all-ones value gives all zeros on the next enabled edge.
- R6: `carry` is 1 exactly when `en_ripple` is 1 and `q` is all ones. It follows `en_ripple` in the same cycle, with no clock edge needed.
- R7: `en_count` has no effect on `carry`.
- R8: Clear wins over load and count: while `clear_n` is low, edges with `load_n` low or with both enables high leave `q` at zero.
- R9: Two stages chained through `carry` (the low stage's carry driving both enables of the high stage) count as one 8-bit binary counter. The high stage advances on the same edge as the low stage wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load strobe, active low |
| din | input | W | Preset value taken on a load |
| en_count | input | 1 | Count enable that does not reach the carry |
| en_ripple | input | 1 | Count enable that also gates the carry |
| q | output | W | Current count |
| carry | output | 1 | Terminal-count carry: en_ripple AND q all ones |

## Verification
The bench chains two instances and drives them with four kinds of pattern.

- **Long enabled runs** cross the nibble boundary and the full 8-bit wrap. These separate a correct in-cycle carry hand-off from a late or missing one.
- **Loads with both enables low** show whether load priority is real. **Loads with both enables high** show the same thing from the other side.
- **A low-nibble value of all ones with one enable dropped at a time** separates the reach of the two enables on the carry and on the count.
- **Clear pulses**, taken on their own, combined with a pending load, and in the middle of a count, check that clear acts without a clock and takes precedence.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2
    } cnt_op_e;
endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic    load_n,
    input  logic    en_count,
    input  logic    en_ripple,
    output cnt_op_e op
);
    logic both_en;

    assign both_en = en_count & en_ripple;

    // Load has priority over counting; enables matter only when not loading.
    always_comb begin
        unique case ({load_n, both_en})
            2'b00:   op = OP_LOAD;
            2'b01:   op = OP_LOAD;
            2'b10:   op = OP_HOLD;
            2'b11:   op = OP_COUNT;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/cnt_next_val.sv
module cnt_next_val
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  cnt_op_e      op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] din,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (op)
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = cur + ONE;   // wraps naturally from all ones
            OP_HOLD:  nxt = cur;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         en_ripple,
    output logic         carry
);
    logic [W:0] chain;

    assign chain[0] = en_ripple;

    // AND chain over the count bits, seeded by the gating enable
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_and
            assign chain[i+1] = chain[i] & cur[i];
        end
    endgenerate

    assign carry = chain[W];
endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         en_count,
    input  logic         en_ripple,
    output logic [W-1:0] q,
    output logic         carry
);
    cnt_op_e      op;
    logic [W-1:0] cnt_r;
    logic [W-1:0] cnt_nxt;

    cnt_op_decode u_dec (
        .load_n    (load_n),
        .en_count  (en_count),
        .en_ripple (en_ripple),
        .op        (op)
    );

    cnt_next_val #(.W(W)) u_next (
        .op  (op),
        .cur (cnt_r),
        .din (din),
        .nxt (cnt_nxt)
    );

    // State register; clear is asynchronous and overrides any operation
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) cnt_r <= '0;
        else          cnt_r <= cnt_nxt;
    end

    cnt_carry #(.W(W)) u_carry (
        .cur       (cnt_r),
        .en_ripple (en_ripple),
        .carry     (carry)
    );

    assign q = cnt_r;
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clear_n,
    input logic         load_n,
    input logic [W-1:0] din,
    input logic         en_count,
    input logic         en_ripple,
    input logic [W-1:0] q,
    input logic         carry
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!clear_n)
        $rose(clear_n) |-> (q == '0));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> (q == $past(din)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && en_count && en_ripple) |=> (q == $past(q) + ONE));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(en_count && en_ripple)) |=> $stable(q));

    // R6
    carry_gate_chk: assert property (@(posedge clk) disable iff (!clear_n)
        carry |-> (en_ripple && (&q)));
endmodule

bind casc_counter casc_counter_chk #(.W(W)) u_chk (
    .clk       (clk),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .din       (din),
    .en_count  (en_count),
    .en_ripple (en_ripple),
    .q         (q),
    .carry     (carry)
);

// File: tb/tb_casc_counter.sv
`timescale 1ns/1ps
module tb_casc_counter;
    typedef struct {
        logic [7:0] val;
        logic       c_lo;
        logic       c_hi;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       clear_n = 1'b0;
    logic       load_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic       en_count = 1'b0;
    logic       en_ripple = 1'b0;
    logic [3:0] q_lo, q_hi;
    logic       c_lo, c_hi;

    int vecs = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] mdl = 8'h00;
    exp_t sb[$];

    always #5 clk = ~clk;

    casc_counter #(.W(4)) dut (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .din(din[3:0]),
        .en_count(en_count), .en_ripple(en_ripple), .q(q_lo), .carry(c_lo)
    );
    casc_counter #(.W(4)) u_hi (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .din(din[7:4]),
        .en_count(c_lo), .en_ripple(c_lo), .q(q_hi), .carry(c_hi)
    );

    task automatic compare(input exp_t e);
        vecs++;
        if ({q_hi, q_lo} !== e.val || c_lo !== e.c_lo || c_hi !== e.c_hi) begin
            fails++;
            $display("FAIL %s: q=%02h c_lo=%b c_hi=%b expected q=%02h c_lo=%b c_hi=%b",
                     e.tag, {q_hi, q_lo}, c_lo, c_hi, e.val, e.c_lo, e.c_hi);
        end
    endtask

    function automatic exp_t predict(input string tag);
        exp_t e;
        e.val  = mdl;
        e.c_lo = en_ripple && (mdl[3:0] == 4'hF);
        e.c_hi = e.c_lo && (mdl[7:4] == 4'hF);
        e.tag  = tag;
        return e;
    endfunction

    // Driver: apply one clock's inputs, advance the model, push expectation
    task automatic step(input logic clr, input logic ld, input logic [7:0] d,
                        input logic ec, input logic er, input string tag);
        logic cl;
        @(negedge clk);
        clear_n = clr; load_n = ld; din = d; en_count = ec; en_ripple = er;
        cl = er && (mdl[3:0] == 4'hF);
        if (!clr)      mdl = 8'h00;
        else if (!ld)  mdl = d;
        else begin
            if (ec && er) mdl[3:0] = mdl[3:0] + 4'h1;
            if (cl)       mdl[7:4] = mdl[7:4] + 4'h1;
        end
        sb.push_back(predict(tag));
    endtask

    // Clear without any clock edge: check between edges
    task automatic async_clear(input string tag);
        @(negedge clk);
        #1 clear_n = 1'b0;
        #1 mdl = 8'h00;
        compare(predict(tag));
    endtask

    // Monitor: after each rising edge pop and compare
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        #3;
        compare(predict("R1 reset state"));
        step(0, 0, 8'hAA, 1, 1, "R8 clear beats load and count");
        step(1, 0, 8'hFC, 0, 0, "R2 load with enables low");
        step(1, 1, 8'h00, 1, 1, "R3 count FD");
        step(1, 1, 8'h00, 1, 1, "R3 count FE");
        step(1, 1, 8'h00, 1, 1, "R6 R9 count FF all carries");
        step(1, 1, 8'h00, 1, 1, "R5 R9 wrap to 00");
        step(1, 1, 8'h00, 1, 1, "R3 count 01");
        step(1, 0, 8'h0D, 1, 1, "R2 load mid-sequence enables high");
        step(1, 1, 8'h00, 1, 1, "R3 count 0E");
        step(1, 1, 8'h00, 1, 1, "R6 count 0F carry low stage");
        step(1, 1, 8'h00, 1, 1, "R9 nibble carry into high stage");
        step(1, 0, 8'h3F, 0, 0, "R2 load 3F");
        step(1, 1, 8'h00, 0, 0, "R4 hold both low");
        step(1, 1, 8'h00, 1, 0, "R4 R6 hold ripple low carry off");
        step(1, 1, 8'h00, 0, 1, "R7 count enable low carry on");
        step(1, 0, 8'h5F, 0, 1, "R2 load 5F");
        step(1, 1, 8'h00, 1, 1, "R9 chain 5F to 60");
        for (int i = 0; i < 20; i++) step(1, 1, 8'h00, 1, 1, "R3 R9 run");
        async_clear("R1 clear without clock");
        step(0, 1, 8'h00, 1, 1, "R8 clear holds during count");
        step(1, 0, 8'hF7, 1, 1, "R2 load after clear");
        for (int i = 0; i < 12; i++) step(1, 1, 8'h00, 1, 1, "R5 R9 full wrap run");
        step(1, 1, 8'h00, 0, 0, "R4 final hold");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end
endmodule